// File: doc/BRIEF.md
# Variable-Length Instruction Decoder

This block decodes one instruction from a stream of 7-bit bytes. A fetch unit presents a 42-bit window whose first bit is the first bit of the instruction, together with a count of how many window bits are real stream data. The block reads a 3-bit format code from the head of the window. It then pulls out the fields that format carries: opcode, register numbers and a 28-bit constant. It also checks that reserved zero fields are clear, and it reports the length of the instruction in bits so the fetch unit can advance its stream pointer.

Both sides of the block use valid/ready handshakes and are separated by one register stage. A window moves in when `in_valid` and `in_ready` are both high. A decoded result stays on the outputs, unchanged, until `out_ready` is high in a cycle where `out_valid` is high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle, so the stage runs at one window per clock when nothing stalls. Every accepted window produces exactly one result. That result is one of three kinds: a good instruction (`out_ok`), an illegal one (`out_illegal`), or padding, where both flags are low.

Top module: `vlid_decoder`

## Requirements
- R1: Handshakes. A window is taken on a clock edge where `in_valid` and `in_ready` are both high, and its result appears with `out_valid` high after that edge. While `out_valid` is high and `out_ready` is low, every output holds its value and `in_ready` is low. `in_ready` is high when `out_valid` is low or `out_ready` is high.
- R2: While reset is asserted, and right after it, `out_valid` is low.
- R3: Stream bit p (counted from 0) is `in_window[41-p]`, and fields are read most significant bit first. Format code 2 (bits 0-2) is register-register: opcode at bits 3-6, source at 7-10, destination at 11-14, and a zero field at 15-20. Its length is 21.
- R4: Format code 3 is register-constant: opcode at bits 3-6, destination at 7-10, a zero field at 11-13, and the constant at 14-41. Its length is 42.
- R5: Format code 4 is single-register: opcode at bits 3-6, register at 7-10 (reported on `out_src`), and a zero field at 11-13. Its length is 14.
- R6: Format code 5 is single-constant: opcode at bits 3-6 and the constant at 7-34. Its length is 35. In both constant formats, constant byte k is made of the 7 stream bits that start at (constant start + 7k). Byte 0 is the least significant byte, so `out_imm[7k+6:7k]` is byte k.
- R7: Format codes 6 (return) and 7 (no-op) have a zero field at bits 3-6 and a length of 7. Their reported opcode is 0.
- R8: Format codes 0 and 1 are unknown. When at least 7 bits are valid, they give `out_illegal`=1, `out_ok`=0, `out_len`=0 and `out_type` equal to the code.
- R9: A known format with all its bits present but a nonzero zero field gives `out_illegal`=1 and `out_ok`=0. `out_type` and `out_len` are those of the format, and the opcode, register and constant outputs are 0.
- R10: When `in_bits` is less than 7, or less than the length of a known format, the result is padding: `out_ok`=0, `out_illegal`=0, and all other result outputs are 0.
- R11: A good instruction has `out_ok`=1, `out_illegal`=0, and `out_len` equal to its format length (7, 14, 21, 35 or 42).
- R12: Any field that a good instruction's format does not carry reads as 0 on its output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Window is offered |
| in_ready | output | 1 | Block can take a window this cycle |
| in_window | input | 42 | Stream bits; bit 41 is the first bit of the instruction |
| in_bits | input | 6 | Number of valid stream bits in the window (0 to 42) |
| out_valid | output | 1 | Decoded result is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_ok | output | 1 | Result is a well-formed instruction |
| out_illegal | output | 1 | Unknown format or nonzero zero field |
| out_type | output | 3 | Format code |
| out_opcode | output | 4 | Opcode |
| out_src | output | 4 | Source register, or the single register |
| out_dst | output | 4 | Destination register |
| out_imm | output | 28 | Constant, byte 0 least significant |
| out_len | output | 6 | Instruction length in bits |

## Verification
The assertions assume that `in_bits` never exceeds 42 while `in_valid` is high, and that the upstream side holds its offer until it is accepted. The stimulus respects both. It draws `in_bits` only from 0 to 42, and it changes a window only after the cycle in which that window was taken. The stimulus also toggles `out_ready` randomly, so that results are held under back-pressure. The window mix covers every format code. It includes full-length windows, windows one bit short of their format length, windows that end right after the format code, and windows with each zero field made nonzero. The constant windows use distinct byte values, so that any error in byte order shows up in the result.

// File: rtl/vlid_pkg.sv
package vlid_pkg;
  localparam int BYTE_W    = 7;
  localparam int TYPE_W    = 3;
  localparam int OP_W      = 4;
  localparam int REG_W     = 4;
  localparam int IMM_BYTES = 4;
  localparam int IMM_W     = BYTE_W * IMM_BYTES;
  localparam int WIN_W     = 6 * BYTE_W;
  localparam int LEN_W     = $clog2(WIN_W + 1);

  // stream bit offsets of each field (bit 0 = first bit of the instruction)
  localparam int P_OP    = TYPE_W;
  localparam int P_REGA  = P_OP + OP_W;
  localparam int P_REGB  = P_REGA + REG_W;
  localparam int P_ZRR   = P_REGB + REG_W;
  localparam int ZRR_W   = 3 * BYTE_W - P_ZRR;
  localparam int P_ZSH   = P_REGB;
  localparam int ZSH_W   = 2 * BYTE_W - P_ZSH;
  localparam int P_IMM_L = 2 * BYTE_W;
  localparam int P_IMM_S = BYTE_W;

  localparam int LEN_RR  = 3 * BYTE_W;
  localparam int LEN_RC  = P_IMM_L + IMM_W;
  localparam int LEN_R   = 2 * BYTE_W;
  localparam int LEN_C   = P_IMM_S + IMM_W;
  localparam int LEN_Z   = BYTE_W;

  typedef enum logic [TYPE_W-1:0] {
    FMT_RSV0 = 3'd0, FMT_RSV1 = 3'd1, FMT_RR  = 3'd2, FMT_RC  = 3'd3,
    FMT_R    = 3'd4, FMT_C    = 3'd5, FMT_RET = 3'd6, FMT_NOP = 3'd7
  } fmt_e;

  typedef struct packed {
    logic [TYPE_W-1:0] code;
    logic [OP_W-1:0]   op;
    logic [REG_W-1:0]  reg_a;
    logic [REG_W-1:0]  reg_b;
    logic [ZRR_W-1:0]  zero_rr;
    logic [ZSH_W-1:0]  zero_sh;
    logic [IMM_W-1:0]  imm_long;
    logic [IMM_W-1:0]  imm_short;
  } raw_t;

  typedef struct packed {
    logic              ok;
    logic              illegal;
    logic [TYPE_W-1:0] kind;
    logic [OP_W-1:0]   opcode;
    logic [REG_W-1:0]  src;
    logic [REG_W-1:0]  dst;
    logic [IMM_W-1:0]  imm;
    logic [LEN_W-1:0]  len;
  } dec_t;
endpackage

// File: rtl/vlid_fields.sv
module vlid_fields
  import vlid_pkg::*;
(
  input  logic [WIN_W-1:0] window,
  output raw_t             raw
);
  // a field that starts at stream bit p with width n sits at window[WIN_W-1-p -: n]
  assign raw.code    = window[WIN_W-1        -: TYPE_W];
  assign raw.op      = window[WIN_W-1-P_OP   -: OP_W];
  assign raw.reg_a   = window[WIN_W-1-P_REGA -: REG_W];
  assign raw.reg_b   = window[WIN_W-1-P_REGB -: REG_W];
  assign raw.zero_rr = window[WIN_W-1-P_ZRR  -: ZRR_W];
  assign raw.zero_sh = window[WIN_W-1-P_ZSH  -: ZSH_W];

  for (genvar k = 0; k < IMM_BYTES; k++) begin : g_imm_byte
    assign raw.imm_long[k*BYTE_W +: BYTE_W]  = window[WIN_W-1-P_IMM_L-k*BYTE_W -: BYTE_W];
    assign raw.imm_short[k*BYTE_W +: BYTE_W] = window[WIN_W-1-P_IMM_S-k*BYTE_W -: BYTE_W];
  end
endmodule

// File: rtl/vlid_classify.sv
module vlid_classify
  import vlid_pkg::*;
(
  input  raw_t             raw,
  input  logic [LEN_W-1:0] nbits,
  output dec_t             dec
);
  logic [LEN_W-1:0]  need;
  logic              known;
  logic              zero_bad;
  logic [OP_W-1:0]   f_op;
  logic [REG_W-1:0]  f_src;
  logic [REG_W-1:0]  f_dst;
  logic [IMM_W-1:0]  f_imm;

  always_comb begin
    need     = '0;
    known    = 1'b1;
    zero_bad = 1'b0;
    f_op     = raw.op;
    f_src    = '0;
    f_dst    = '0;
    f_imm    = '0;
    unique case (fmt_e'(raw.code))
      FMT_RR: begin
        need     = LEN_W'(LEN_RR);
        zero_bad = |raw.zero_rr;
        f_src    = raw.reg_a;
        f_dst    = raw.reg_b;
      end
      FMT_RC: begin
        need     = LEN_W'(LEN_RC);
        zero_bad = |raw.zero_sh;
        f_dst    = raw.reg_a;
        f_imm    = raw.imm_long;
      end
      FMT_R: begin
        need     = LEN_W'(LEN_R);
        zero_bad = |raw.zero_sh;
        f_src    = raw.reg_a;
      end
      FMT_C: begin
        need     = LEN_W'(LEN_C);
        f_imm    = raw.imm_short;
      end
      FMT_RET, FMT_NOP: begin
        need     = LEN_W'(LEN_Z);
        zero_bad = |raw.op;
        f_op     = '0;
      end
      default: begin
        need     = '0;
        known    = 1'b0;
        f_op     = '0;
      end
    endcase
  end

  always_comb begin
    dec = '0;
    if (nbits < LEN_W'(BYTE_W)) begin
      dec = '0;
    end else if (!known) begin
      dec.illegal = 1'b1;
      dec.kind    = raw.code;
    end else if (nbits < need) begin
      dec = '0;
    end else if (zero_bad) begin
      dec.illegal = 1'b1;
      dec.kind    = raw.code;
      dec.len     = need;
    end else begin
      dec.ok     = 1'b1;
      dec.kind   = raw.code;
      dec.opcode = f_op;
      dec.src    = f_src;
      dec.dst    = f_dst;
      dec.imm    = f_imm;
      dec.len    = need;
    end
  end
endmodule

// File: rtl/vlid_hold_stage.sv
module vlid_hold_stage #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_valid,
  output logic             up_ready,
  input  logic [WIDTH-1:0] up_data,
  output logic             dn_valid,
  input  logic             dn_ready,
  output logic [WIDTH-1:0] dn_data
);
  logic             full_q;
  logic [WIDTH-1:0] data_q;

  assign up_ready = !full_q || dn_ready;
  assign dn_valid = full_q;
  assign dn_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (up_ready) begin
      full_q <= up_valid;
      if (up_valid) data_q <= up_data;
    end
  end
endmodule

// File: rtl/vlid_decoder.sv
module vlid_decoder
  import vlid_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WIN_W-1:0]  in_window,
  input  logic [LEN_W-1:0]  in_bits,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_ok,
  output logic              out_illegal,
  output logic [TYPE_W-1:0] out_type,
  output logic [OP_W-1:0]   out_opcode,
  output logic [REG_W-1:0]  out_src,
  output logic [REG_W-1:0]  out_dst,
  output logic [IMM_W-1:0]  out_imm,
  output logic [LEN_W-1:0]  out_len
);
  localparam int DEC_W = $bits(dec_t);

  raw_t raw;
  dec_t dec_d;
  dec_t dec_q;
  logic [DEC_W-1:0] dec_bits_q;

  vlid_fields u_fields (
    .window (in_window),
    .raw    (raw)
  );

  vlid_classify u_classify (
    .raw   (raw),
    .nbits (in_bits),
    .dec   (dec_d)
  );

  vlid_hold_stage #(.WIDTH(DEC_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (dec_d),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (dec_bits_q)
  );

  assign dec_q       = dec_t'(dec_bits_q);
  assign out_ok      = dec_q.ok;
  assign out_illegal = dec_q.illegal;
  assign out_type    = dec_q.kind;
  assign out_opcode  = dec_q.opcode;
  assign out_src     = dec_q.src;
  assign out_dst     = dec_q.dst;
  assign out_imm     = dec_q.imm;
  assign out_len     = dec_q.len;
endmodule

// File: rtl/vlid_decoder_checker.sv
module vlid_decoder_checker
  import vlid_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [LEN_W-1:0]  in_bits,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_ok,
  input logic              out_illegal,
  input logic [TYPE_W-1:0] out_type,
  input logic [OP_W-1:0]   out_opcode,
  input logic [REG_W-1:0]  out_src,
  input logic [REG_W-1:0]  out_dst,
  input logic [IMM_W-1:0]  out_imm,
  input logic [LEN_W-1:0]  out_len
);
  assert_in_bits_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> in_bits <= LEN_W'(WIN_W));

  assert_hold_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_ok) && $stable(out_illegal)
      && $stable(out_type) && $stable(out_opcode) && $stable(out_src)
      && $stable(out_dst) && $stable(out_imm) && $stable(out_len));

  assert_stall_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_ok && out_illegal));

  assert_good_len_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ok |-> (out_len == LEN_W'(LEN_Z) || out_len == LEN_W'(LEN_R)
      || out_len == LEN_W'(LEN_RR) || out_len == LEN_W'(LEN_C) || out_len == LEN_W'(LEN_RC)));

  assert_pad_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ok && !out_illegal |-> out_len == '0 && out_type == '0
      && out_opcode == '0 && out_src == '0 && out_dst == '0 && out_imm == '0);

  assert_illegal_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_opcode == '0 && out_src == '0 && out_dst == '0 && out_imm == '0);

  assert_unknown_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_type <= 3'd1 |-> !out_ok);
endmodule

bind vlid_decoder vlid_decoder_checker u_vlid_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_bits     (in_bits),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_ok      (out_ok),
  .out_illegal (out_illegal),
  .out_type    (out_type),
  .out_opcode  (out_opcode),
  .out_src     (out_src),
  .out_dst     (out_dst),
  .out_imm     (out_imm),
  .out_len     (out_len)
);

// File: tb/vlid_decoder_bench.sv
module vlid_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [41:0] in_window = '0;
  logic [5:0]  in_bits = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        out_ok, out_illegal;
  logic [2:0]  out_type;
  logic [3:0]  out_opcode, out_src, out_dst;
  logic [27:0] out_imm;
  logic [5:0]  out_len;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vlid_decoder u_vlid_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_window(in_window), .in_bits(in_bits), .out_valid(out_valid),
    .out_ready(out_ready), .out_ok(out_ok), .out_illegal(out_illegal),
    .out_type(out_type), .out_opcode(out_opcode), .out_src(out_src),
    .out_dst(out_dst), .out_imm(out_imm), .out_len(out_len)
  );

  // expected result record, built behaviourally
  typedef struct {
    bit ok; bit bad; int kind; int op; int src; int dst; longint imm; int len;
  } exp_t;

  exp_t exp_q;
  bit   exp_v = 0;
  logic [41:0] win_q[$];
  int          bits_q[$];

  function automatic longint grab(logic [41:0] w, int pos, int n);
    longint v = 0;
    for (int i = 0; i < n; i++) v = v * 2 + longint'(w[41 - pos - i]);
    return v;
  endfunction

  function automatic logic [41:0] put(logic [41:0] w, int pos, int n, longint val);
    logic [41:0] r = w;
    for (int i = 0; i < n; i++) r[41 - pos - i] = val[n - 1 - i];
    return r;
  endfunction

  function automatic longint imm_at(logic [41:0] w, int pos);
    longint v = 0;
    for (int k = 0; k < 4; k++) v = v + (grab(w, pos + 7 * k, 7) << (7 * k));
    return v;
  endfunction

  function automatic exp_t model(logic [41:0] w, int nb);
    exp_t e = '{0, 0, 0, 0, 0, 0, 0, 0};
    int code = int'(grab(w, 0, 3));
    int need;
    bit zb;
    case (code)
      2: begin need = 21; zb = grab(w, 15, 6) != 0; end
      3: begin need = 42; zb = grab(w, 11, 3) != 0; end
      4: begin need = 14; zb = grab(w, 11, 3) != 0; end
      5: begin need = 35; zb = 0; end
      6, 7: begin need = 7; zb = grab(w, 3, 4) != 0; end
      default: begin need = 0; zb = 0; end
    endcase
    if (nb < 7) return e;
    if (need == 0) begin e.bad = 1; e.kind = code; return e; end
    if (nb < need) return e;
    e.kind = code;
    e.len  = need;
    if (zb) begin e.bad = 1; return e; end
    e.ok = 1;
    if (code != 6 && code != 7) e.op = int'(grab(w, 3, 4));
    if (code == 2) begin e.src = int'(grab(w, 7, 4)); e.dst = int'(grab(w, 11, 4)); end
    if (code == 3) begin e.dst = int'(grab(w, 7, 4)); e.imm = imm_at(w, 14); end
    if (code == 4) e.src = int'(grab(w, 7, 4));
    if (code == 5) e.imm = imm_at(w, 7);
    return e;
  endfunction

  task automatic check(string tag, string what, longint act, longint expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic string fmt_tag(exp_t e);
    if (!e.ok && !e.bad) return "R10";
    if (e.bad) return (e.len == 0) ? "R8" : "R9";
    case (e.kind)
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R7";
    endcase
  endfunction

  // cycle model of the one-entry stage
  always @(posedge clk) begin
    if (!rst_n) exp_v <= 0;
    else if (!exp_v || out_ready) begin
      exp_v <= in_valid;
      if (in_valid) exp_q <= model(in_window, int'(in_bits));
    end
  end

  task automatic compare();
    string t;
    check("R1", "in_ready", in_ready, (!exp_v || out_ready));
    check("R1", "out_valid", out_valid, exp_v);
    if (exp_v && out_valid) begin
      t = fmt_tag(exp_q);
      check(t, "ok", out_ok, exp_q.ok);
      check(t, "illegal", out_illegal, exp_q.bad);
      check(t, "type", out_type, exp_q.kind);
      check(exp_q.ok ? "R11" : t, "len", out_len, exp_q.len);
      check((exp_q.ok && exp_q.op == 0) ? "R12" : t, "opcode", out_opcode, exp_q.op);
      check((exp_q.ok && exp_q.kind != 2 && exp_q.kind != 4) ? "R12" : t, "src", out_src, exp_q.src);
      check((exp_q.ok && exp_q.kind != 2 && exp_q.kind != 3) ? "R12" : t, "dst", out_dst, exp_q.dst);
      check((exp_q.ok && exp_q.kind != 3 && exp_q.kind != 5) ? "R12" : t, "imm", out_imm, exp_q.imm);
    end
  endtask

  task automatic add(logic [41:0] w, int nb);
    win_q.push_back(w);
    bits_q.push_back(nb);
  endtask

  task automatic build();
    logic [41:0] w;
    // R3 register-register, full and one bit short
    w = put(put(put(put(42'd0, 0, 3, 2), 3, 4, 9), 7, 4, 5), 11, 4, 12);
    add(w, 21); add(w, 20); add(w, 42);
    add(put(w, 20, 1, 1), 21);                 // R9 zero field
    // R4 register-constant, distinct bytes to expose order
    w = put(put(put(42'd0, 0, 3, 3), 3, 4, 4'hA), 7, 4, 3);
    w = put(put(put(put(w, 14, 7, 7'h01), 21, 7, 7'h22), 28, 7, 7'h43), 35, 7, 7'h7F);
    add(w, 42); add(w, 41);
    add(put(w, 12, 1, 1), 42);                 // R9
    // R5 single register
    w = put(put(put(42'd0, 0, 3, 4), 3, 4, 6), 7, 4, 15);
    add(w, 14); add(w, 13);
    add(put(w, 13, 1, 1), 14);                 // R9
    // R6 single constant
    w = put(put(42'd0, 0, 3, 5), 3, 4, 1);
    w = put(put(put(put(w, 7, 7, 7'h55), 14, 7, 7'h0C), 21, 7, 7'h30), 28, 7, 7'h6B);
    add(w, 35); add(w, 34); add(w, 42);
    // R7 return / no-op
    add(put(42'd0, 0, 3, 6), 7);
    add(put(42'd0, 0, 3, 7), 7);
    add(put(put(42'd0, 0, 3, 7), 5, 1, 1), 7);  // R9
    // R8 unknown codes
    add(put(42'h3FFFFFFFFFF, 0, 3, 0), 42);
    add(put(42'd0, 0, 3, 1), 7);
    // R10 padding
    add(put(42'd0, 0, 3, 6), 3);
    add(put(42'd0, 0, 3, 1), 3);
    add(42'd0, 0);
    for (int i = 0; i < 600; i++) begin
      logic [41:0] r = {$urandom, $urandom};
      int pick = $urandom_range(0, 3);
      int nb;
      if (pick == 0) nb = $urandom_range(0, 42);
      else begin
        case (int'(grab(r, 0, 3)))
          2: nb = 21; 3: nb = 42; 4: nb = 14; 5: nb = 35; default: nb = 7;
        endcase
        if (pick == 1) begin
          r = put(r, 15, 6, 0); r = put(r, 11, 3, (grab(r, 0, 3) == 2) ? grab(r, 11, 3) : 0);
          if (grab(r, 0, 3) >= 6) r = put(r, 3, 4, 0);
        end
      end
      add(r, nb);
    end
  endtask

  initial begin
    build();
    repeat (3) @(negedge clk);
    check("R2", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", "out_valid after reset", out_valid, 0);
    while (win_q.size() > 0 || exp_v) begin
      compare();
      // hold an offer until taken
      if (in_valid && in_ready) begin
        void'(win_q.pop_front()); void'(bits_q.pop_front());
      end
      out_ready = ($urandom_range(0, 3) != 0);
      if (win_q.size() > 0 && (in_valid || $urandom_range(0, 4) != 0)) begin
        in_valid  = 1'b1;
        in_window = win_q[0];
        in_bits   = 6'(bits_q[0]);
      end else in_valid = 1'b0;
      @(negedge clk);
    end
    compare();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule